// File: doc/BRIEF.md
# Mode-Selectable Command/Address Re-Driver

This block sits between a memory controller and a set of SDRAM devices. It re-drives every command, address, bank, chip-select, clock-enable and byte-mask signal toward the devices. A static mode pin selects one of two behaviours. In registered mode, each signal is captured on one rising edge and presented on the next. In buffered mode, each signal passes through in the same cycle.

The block also decodes the four active-low chip selects into two physical rank indications. It reports three values that the controller's read-data capture logic needs: the module-level CAS latency, the read byte-mask latency and the write byte-mask latency. Each of these shifts by one clock between the two modes. The mode pin is sampled only while reset is asserted. After reset is released, the chosen mode stays frozen until the next reset.

Top module: `ca_redrive`

## Requirements
- R1: With registered mode selected at reset, `cs_n_o`, `ras_n_o`, `cas_n_o`, `we_n_o`, `ba_o` and `addr_o` show the input values captured at a rising edge. They change right after that edge and hold until the next rising edge.
- R2: With buffered mode selected at reset, every re-driven output equals its input within the same cycle, with no clock edge in between.
- R3: `dimm_cl_o` equals `device_cl_i + 1` in registered mode and equals `device_cl_i` in buffered mode, computed without overflow (output one bit wider).
- R4: `rd_mask_lat_o` reads 3 in registered mode and 2 in buffered mode.
- R5: `wr_mask_lat_o` reads 1 in registered mode and 0 in buffered mode.
- R6: `rank_sel_o[0]` is high when chip select 0 or 2 (bits 0 or 2 of `cs_n_o`) is low. `rank_sel_o[1]` is high when chip select 1 or 3 is low. Chip selects are active low, and rank selection follows the device-side outputs.
- R7: `cke_o` is re-driven through the same path as the other controls: one edge late in registered mode, same cycle in buffered mode.
- R8: In registered mode, during reset and until the first capture after it, the outputs are idle: all chip selects high, RAS/CAS/WE high, all byte masks high, clock enable low, and bank and address zero.
- R9: `reg_mode_i` is sampled only while `rst_ni` is low. A change on it after reset has no effect on the output timing or on the reported latencies.
- R10: `dqm_o` is re-driven through the same path as the controls, one bit per byte, with a high bit masking its byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_mode_i | input | 1 | 1 = registered mode, 0 = buffered mode (sampled during reset) |
| device_cl_i | input | CL_W | Programmed device CAS latency |
| cs_n_i | input | NUM_CS | Chip selects from controller, active low |
| ras_n_i | input | 1 | Row strobe from controller, active low |
| cas_n_i | input | 1 | Column strobe from controller, active low |
| we_n_i | input | 1 | Write enable from controller, active low |
| cke_i | input | 1 | Clock enable from controller |
| ba_i | input | BA_W | Bank address from controller |
| addr_i | input | ADDR_W | Row/column address from controller |
| dqm_i | input | NUM_BYTES | Byte masks from controller |
| cs_n_o | output | NUM_CS | Chip selects to devices |
| ras_n_o | output | 1 | Row strobe to devices |
| cas_n_o | output | 1 | Column strobe to devices |
| we_n_o | output | 1 | Write enable to devices |
| cke_o | output | 1 | Clock enable to all devices |
| ba_o | output | BA_W | Bank address to devices |
| addr_o | output | ADDR_W | Address to devices |
| dqm_o | output | NUM_BYTES | Byte masks to devices |
| rank_sel_o | output | NUM_RANKS | Physical rank selected, active high |
| dimm_cl_o | output | CL_W+1 | Module-level CAS latency |
| rd_mask_lat_o | output | LAT_W | Read byte-mask latency in clocks |
| wr_mask_lat_o | output | LAT_W | Write byte-mask latency in clocks |

## Verification
Registered mode is driven with back-to-back distinct command words. Each output is sampled both just before and just after an edge. This separates a one-edge delay from a pass-through and from a stuck register. Buffered mode uses the same patterns, with the outputs sampled before any edge, which exposes any stray register stage. Chip-select patterns with one, two or no selects low, mixed across ranks, tell a correct rank decode apart from a swapped or merged one. Flipping the mode pin after reset shows whether the mode is really frozen.

// File: rtl/ca_pkg.sv
package ca_pkg;
  typedef enum logic {
    MODE_BUF = 1'b0,
    MODE_REG = 1'b1
  } ca_mode_e;
endpackage

// File: rtl/ca_pipe_stage.sv
module ca_pipe_stage #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bypass_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_r;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_r <= RST_VAL;
    else         q_r <= d_i;
  end

  assign q_o = bypass_i ? d_i : q_r;
endmodule

// File: rtl/ca_rank_map.sv
module ca_rank_map #(
  parameter int unsigned NUM_CS    = 4,
  parameter int unsigned NUM_RANKS = 2
) (
  input  logic [NUM_CS-1:0]    cs_n_i,
  output logic [NUM_RANKS-1:0] rank_sel_o
);
  // chip select c belongs to rank c mod NUM_RANKS
  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    always_comb begin
      rank_sel_o[r] = 1'b0;
      for (int c = 0; c < NUM_CS; c++) begin
        if ((c % NUM_RANKS) == r && !cs_n_i[c]) rank_sel_o[r] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ca_latency.sv
module ca_latency #(
  parameter int unsigned CL_W         = 3,
  parameter int unsigned LAT_W        = 2,
  parameter int unsigned RD_MASK_BASE = 2,
  parameter int unsigned WR_MASK_BASE = 0
) (
  input  logic             reg_mode_i,
  input  logic [CL_W-1:0]  device_cl_i,
  output logic [CL_W:0]    dimm_cl_o,
  output logic [LAT_W-1:0] rd_mask_lat_o,
  output logic [LAT_W-1:0] wr_mask_lat_o
);
  localparam logic [LAT_W-1:0] RD_BASE = LAT_W'(RD_MASK_BASE);
  localparam logic [LAT_W-1:0] WR_BASE = LAT_W'(WR_MASK_BASE);

  logic [LAT_W-1:0] extra;
  assign extra = {{(LAT_W-1){1'b0}}, reg_mode_i};

  assign dimm_cl_o     = {1'b0, device_cl_i} + {{CL_W{1'b0}}, reg_mode_i};
  assign rd_mask_lat_o = RD_BASE + extra;
  assign wr_mask_lat_o = WR_BASE + extra;
endmodule

// File: rtl/ca_redrive.sv
module ca_redrive #(
  parameter int unsigned NUM_CS    = 4,
  parameter int unsigned NUM_RANKS = 2,
  parameter int unsigned BA_W      = 2,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_BYTES = 8,
  parameter int unsigned CL_W      = 3,
  parameter int unsigned LAT_W     = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_mode_i,
  input  logic [CL_W-1:0]      device_cl_i,
  input  logic [NUM_CS-1:0]    cs_n_i,
  input  logic                 ras_n_i,
  input  logic                 cas_n_i,
  input  logic                 we_n_i,
  input  logic                 cke_i,
  input  logic [BA_W-1:0]      ba_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [NUM_BYTES-1:0] dqm_i,
  output logic [NUM_CS-1:0]    cs_n_o,
  output logic                 ras_n_o,
  output logic                 cas_n_o,
  output logic                 we_n_o,
  output logic                 cke_o,
  output logic [BA_W-1:0]      ba_o,
  output logic [ADDR_W-1:0]    addr_o,
  output logic [NUM_BYTES-1:0] dqm_o,
  output logic [NUM_RANKS-1:0] rank_sel_o,
  output logic [CL_W:0]        dimm_cl_o,
  output logic [LAT_W-1:0]     rd_mask_lat_o,
  output logic [LAT_W-1:0]     wr_mask_lat_o
);
  import ca_pkg::*;

  localparam int unsigned BUS_W = 4 + NUM_CS + BA_W + ADDR_W + NUM_BYTES;
  localparam logic [BUS_W-1:0] IDLE_BUS = {1'b0, 3'b111, {NUM_CS{1'b1}},
                                           {BA_W{1'b0}}, {ADDR_W{1'b0}},
                                           {NUM_BYTES{1'b1}}};

  ca_mode_e mode_q;

  // mode follows the pin only while reset is held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= reg_mode_i ? MODE_REG : MODE_BUF;
  end

  logic [BUS_W-1:0] bus_in, bus_out;

  assign bus_in = {cke_i, ras_n_i, cas_n_i, we_n_i, cs_n_i, ba_i, addr_i, dqm_i};

  ca_pipe_stage #(
    .W       (BUS_W),
    .RST_VAL (IDLE_BUS)
  ) u_stage (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bypass_i (mode_q == MODE_BUF),
    .d_i      (bus_in),
    .q_o      (bus_out)
  );

  assign {cke_o, ras_n_o, cas_n_o, we_n_o, cs_n_o, ba_o, addr_o, dqm_o} = bus_out;

  ca_rank_map #(
    .NUM_CS    (NUM_CS),
    .NUM_RANKS (NUM_RANKS)
  ) u_rank (
    .cs_n_i     (cs_n_o),
    .rank_sel_o (rank_sel_o)
  );

  ca_latency #(
    .CL_W         (CL_W),
    .LAT_W        (LAT_W),
    .RD_MASK_BASE (2),
    .WR_MASK_BASE (0)
  ) u_lat (
    .reg_mode_i    (mode_q == MODE_REG),
    .device_cl_i   (device_cl_i),
    .dimm_cl_o     (dimm_cl_o),
    .rd_mask_lat_o (rd_mask_lat_o),
    .wr_mask_lat_o (wr_mask_lat_o)
  );
endmodule

// File: rtl/ca_redrive_chk.sv
module ca_redrive_chk #(
  parameter int unsigned NUM_CS    = 4,
  parameter int unsigned NUM_RANKS = 2,
  parameter int unsigned BA_W      = 2,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned NUM_BYTES = 8,
  parameter int unsigned CL_W      = 3,
  parameter int unsigned LAT_W     = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 mode_reg_i,
  input logic [CL_W-1:0]      device_cl_i,
  input logic [NUM_CS-1:0]    cs_n_i,
  input logic                 ras_n_i,
  input logic                 cke_i,
  input logic [ADDR_W-1:0]    addr_i,
  input logic [NUM_BYTES-1:0] dqm_i,
  input logic [NUM_CS-1:0]    cs_n_o,
  input logic                 ras_n_o,
  input logic                 cke_o,
  input logic [ADDR_W-1:0]    addr_o,
  input logic [NUM_BYTES-1:0] dqm_o,
  input logic [NUM_RANKS-1:0] rank_sel_o,
  input logic [CL_W:0]        dimm_cl_o,
  input logic [LAT_W-1:0]     rd_mask_lat_o,
  input logic [LAT_W-1:0]     wr_mask_lat_o
);
  logic armed_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  AST_REG_ONE_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && mode_reg_i |-> addr_o == $past(addr_i) && cs_n_o == $past(cs_n_i)
                              && ras_n_o == $past(ras_n_i)); // R1

  AST_BUF_SAME_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_reg_i |-> addr_o == addr_i && cs_n_o == cs_n_i); // R2

  AST_CL_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dimm_cl_o > {1'b0, device_cl_i}) == mode_reg_i); // R3

  AST_RD_MASK_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_reg_i |-> rd_mask_lat_o == LAT_W'(3)); // R4

  AST_WR_MASK_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mask_lat_o == {{(LAT_W-1){1'b0}}, mode_reg_i}); // R5

  AST_RANK_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(rank_sel_o) <= $countones(~cs_n_o)); // R6

  AST_CKE_PATH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && mode_reg_i |-> cke_o == $past(cke_i) && dqm_o == $past(dqm_i)); // R7

  AST_MODE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> $stable(mode_reg_i)); // R9

  always @(posedge clk_i) begin
    if (!rst_ni && mode_reg_i) begin
      AST_RESET_IDLE: assert (&cs_n_o && ras_n_o && &dqm_o && !cke_o); // R8
    end
  end
endmodule

bind ca_redrive ca_redrive_chk #(
  .NUM_CS(NUM_CS), .NUM_RANKS(NUM_RANKS), .BA_W(BA_W), .ADDR_W(ADDR_W),
  .NUM_BYTES(NUM_BYTES), .CL_W(CL_W), .LAT_W(LAT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_reg_i(mode_q == ca_pkg::MODE_REG),
  .device_cl_i(device_cl_i), .cs_n_i(cs_n_i), .ras_n_i(ras_n_i), .cke_i(cke_i),
  .addr_i(addr_i), .dqm_i(dqm_i), .cs_n_o(cs_n_o), .ras_n_o(ras_n_o),
  .cke_o(cke_o), .addr_o(addr_o), .dqm_o(dqm_o), .rank_sel_o(rank_sel_o),
  .dimm_cl_o(dimm_cl_o), .rd_mask_lat_o(rd_mask_lat_o), .wr_mask_lat_o(wr_mask_lat_o)
);

// File: tb/ca_redrive_bench.sv
module ca_redrive_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_mode = 1'b1;
  logic [2:0]  device_cl = 3'd2;
  logic [3:0]  cs_n = 4'hF;
  logic        ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, cke = 1'b0;
  logic [1:0]  ba = '0;
  logic [11:0] addr = '0;
  logic [7:0]  dqm = 8'hFF;

  logic [3:0]  cs_n_o;
  logic        ras_n_o, cas_n_o, we_n_o, cke_o;
  logic [1:0]  ba_o;
  logic [11:0] addr_o;
  logic [7:0]  dqm_o;
  logic [1:0]  rank_sel_o;
  logic [3:0]  dimm_cl_o;
  logic [1:0]  rd_lat_o, wr_lat_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ca_redrive u_ca_redrive (
    .clk_i(clk), .rst_ni(rst_n), .reg_mode_i(reg_mode), .device_cl_i(device_cl),
    .cs_n_i(cs_n), .ras_n_i(ras_n), .cas_n_i(cas_n), .we_n_i(we_n), .cke_i(cke),
    .ba_i(ba), .addr_i(addr), .dqm_i(dqm),
    .cs_n_o(cs_n_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .we_n_o(we_n_o),
    .cke_o(cke_o), .ba_o(ba_o), .addr_o(addr_o), .dqm_o(dqm_o),
    .rank_sel_o(rank_sel_o), .dimm_cl_o(dimm_cl_o),
    .rd_mask_lat_o(rd_lat_o), .wr_mask_lat_o(wr_lat_o)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %0h exp %0h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] out_word();
    return {cke_o, ras_n_o, cas_n_o, we_n_o, cs_n_o, ba_o, addr_o, dqm_o};
  endfunction

  function automatic logic [31:0] in_word();
    return {cke, ras_n, cas_n, we_n, cs_n, ba, addr, dqm};
  endfunction

  task automatic drive(input logic [3:0] c, input logic r, input logic ca, input logic w,
                       input logic k, input logic [1:0] b, input logic [11:0] a,
                       input logic [7:0] m);
    @(negedge clk);
    cs_n = c; ras_n = r; cas_n = ca; we_n = w; cke = k; ba = b; addr = a; dqm = m;
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst_n = 1'b0;
    reg_mode = mode;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_idle();
    do_reset(1'b1);
    // inputs are non-idle; outputs must stay idle until first capture
    @(negedge clk);
    rst_n = 1'b0;
    cs_n = 4'h0; ras_n = 0; cas_n = 0; we_n = 0; cke = 1; addr = 12'hABC; dqm = 8'h00;
    #2;
    chk("R8 cs_n idle", cs_n_o, 4'hF);
    chk("R8 ras/cas/we idle", {ras_n_o, cas_n_o, we_n_o}, 3'b111);
    chk("R8 dqm idle", dqm_o, 8'hFF);
    chk("R8 cke low", cke_o, 1'b0);
    chk("R8 addr/ba zero", {ba_o, addr_o}, 14'h0);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk("R8 idle held until capture", out_word(), {1'b0, 3'b111, 4'hF, 2'b00, 12'h000, 8'hFF});
  endtask

  task automatic t_reg_pipe();
    logic [31:0] prev;
    drive(4'b1110, 0, 1, 1, 1, 2'd1, 12'h123, 8'h0F);
    prev = in_word();
    @(posedge clk); #1;
    chk("R1 reg capture A", out_word(), prev);
    drive(4'b1101, 1, 0, 0, 0, 2'd2, 12'hFED, 8'hA5);
    #3;
    chk("R1 held before edge", out_word(), prev);
    chk("R7 cke held before edge", cke_o, 1'b1);
    prev = in_word();
    @(posedge clk); #1;
    chk("R1 reg capture B", {ras_n_o, cas_n_o, we_n_o, ba_o, addr_o}, {3'b100, 2'd2, 12'hFED});
    chk("R7 cke one edge late", cke_o, 1'b0);
    chk("R10 dqm one edge late", dqm_o, 8'hA5);
  endtask

  task automatic t_rank(input string tag);
    logic [3:0] pat [5] = '{4'b1011, 4'b0111, 4'b1010, 4'b1100, 4'b1111};
    logic [1:0] exp [5] = '{2'b01, 2'b10, 2'b01, 2'b11, 2'b00};
    for (int i = 0; i < 5; i++) begin
      drive(pat[i], 1, 1, 1, 1, 2'd0, 12'h0, 8'h00);
      if (reg_mode) begin
        @(posedge clk); #1;
      end else #2;
      chk({"R6 rank ", tag}, rank_sel_o, exp[i]);
    end
  endtask

  task automatic t_latency(input logic reg_m);
    logic [2:0] cls [3] = '{3'd2, 3'd3, 3'd7};
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      device_cl = cls[i];
      #1;
      chk("R3 dimm cl", dimm_cl_o, {1'b0, cls[i]} + {3'b0, reg_m});
    end
    chk("R4 read mask latency", rd_lat_o, reg_m ? 2'd3 : 2'd2);
    chk("R5 write mask latency", wr_lat_o, reg_m ? 2'd1 : 2'd0);
  endtask

  task automatic t_mode_static();
    logic [31:0] prev;
    prev = out_word();
    @(negedge clk);
    reg_mode = 1'b0;
    device_cl = 3'd3;
    addr = 12'h5A5; cs_n = 4'b0110;
    #2;
    chk("R9 no pass-through after pin flip", out_word(), prev);
    chk("R9 cl unchanged after pin flip", dimm_cl_o, 4'd4);
    @(posedge clk); #1;
    chk("R9 still one edge late", addr_o, 12'h5A5);
    @(negedge clk);
    reg_mode = 1'b1;
  endtask

  task automatic t_buffered();
    do_reset(1'b0);
    drive(4'b0101, 0, 0, 1, 1, 2'd3, 12'h9C3, 8'h3C);
    #2;
    chk("R2 same cycle word", out_word(), in_word());
    drive(4'b1011, 1, 1, 0, 0, 2'd0, 12'h001, 8'hC3);
    #1;
    chk("R2 second word", {ras_n_o, cas_n_o, we_n_o, ba_o, addr_o}, {3'b110, 2'd0, 12'h001});
    chk("R7 cke same cycle", cke_o, 1'b0);
    chk("R10 dqm same cycle", dqm_o, 8'hC3);
  endtask

  initial begin
    t_reset_idle();
    t_reg_pipe();
    t_rank("registered");
    t_latency(1'b1);
    t_mode_static();
    t_buffered();
    t_rank("buffered");
    t_latency(1'b0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog got timeout exp completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule